// File: doc/BRIEF.md
# Crossbar-Routed General Purpose I/O Port

This block is one 8-bit general purpose I/O port for a small controller's special function register bus. An output latch holds the data each pin drives. A normal read of the port returns the synchronized levels at the pins. A read that the bus flags as read-modify-write returns the latch instead, so that bit operations do not copy pin levels into the latch. A single-bit write path lets the bit-addressable port change one latch bit at a time.

A control register holds the routing setup:
- a global crossbar enable;
- three route enables, one each for the timer 0 input, the timer 1 input and the counter external input;
- a weak pull-up disable.

When the crossbar is enabled, each enabled function takes the lowest-numbered free pin. The order is timer 0, then timer 1, then the counter input. A claimed pin becomes an input for its peripheral. Every unclaimed pin is GPIO and is driven from the latch. A mode register selects push-pull or open-drain for each pin. While the crossbar is disabled, every pin is released.

Top module: `gpio_xbar_port`

## Requirements
- R1: A byte write to the port address (0x80) stores the data in the output latch. A read with `bus_rmw` high at that address returns the latch.
- R2: A read of the port address with `bus_rmw` low returns each pin's level two clock edges after it appears on `pin_in`. This holds even for pins claimed by the crossbar.
- R3: A single-bit write (`bus_bit_wr`, address 0x80) sets latch bit `bus_bit_sel` to `bus_bit_val`. All other latch bits are left unchanged.
- R4: The control register at address 0xE3 stores five bits: bit 7 is the pull-up disable, bit 6 is the crossbar enable, bit 2 routes timer 1, bit 1 routes timer 0 and bit 0 routes the counter input. Bits 5 to 3 read as 0 and ignore writes. Reads of unmapped addresses return 0.
- R5: While control bit 6 is 0, `pin_oe` and `pin_out` are all 0. The three peripheral inputs also read 0.
- R6: With the crossbar enabled, the enabled functions claim the lowest-numbered pins, in the order timer 0, timer 1, counter input. A claimed pin has `pin_oe` = 0, and its peripheral output follows that pin's synchronized level. A function that is not routed reads 0.
- R7: With the crossbar enabled, an unclaimed pin whose mode bit is 1 (push-pull) has `pin_oe` = 1 and `pin_out` equal to its latch bit. The mode register is at address 0xA4.
- R8: With the crossbar enabled, an unclaimed pin whose mode bit is 0 (open-drain) has `pin_out` = 0 and `pin_oe` equal to the inverse of its latch bit.
- R9: `pin_pullup[i]` is 1 exactly when control bit 7 is 0 and mode bit i is 0.
- R10: After reset, the latch is 0xFF, the control register is 0x00 and the mode register is 0x00. All pins are released and all pull-ups are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bit_wr | input | 1 | Single-bit write strobe |
| bus_bit_sel | input | 3 | Bit number for a single-bit write |
| bus_bit_val | input | 1 | Bit value for a single-bit write |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as read-modify-write |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin output data |
| pin_oe | output | 8 | Pin output enables |
| pin_pullup | output | 8 | Weak pull-up enables |
| periph_t0 | output | 1 | Routed timer 0 input |
| periph_t1 | output | 1 | Routed timer 1 input |
| periph_eci | output | 1 | Routed counter external input |

## Verification
A wrong latch value appears in the same cycle on a read-modify-write read. It also shows on `pin_out` or `pin_oe` of any unclaimed GPIO pin on the clock edge after the write. A wrong claim mask shows at once in two ways: an output enable on a pin that should be an input, or a peripheral input taken from the wrong pin. A fault in the synchronizer shows as a normal read that changes one edge too early or too late. The bench therefore samples exactly two edges after each pin change.

// File: rtl/gpio_xbar_pkg.sv
// Package: shared types and constants for the crossbar-routed GPIO port.
// Assumes an 8-bit register bus with byte-wide data.
package gpio_xbar_pkg;

    // Stored control fields; bits 5..3 of the register are not stored.
    typedef struct packed {
        logic pu_off;   // bit 7
        logic xbar_en;  // bit 6
        logic t1_en;    // bit 2
        logic t0_en;    // bit 1
        logic eci_en;   // bit 0
    } ctrl_t;

    localparam int BUS_W = 8;

    // Pack stored control fields into a bus byte.
    function automatic logic [BUS_W-1:0] ctrl_to_byte(ctrl_t c);
        return {c.pu_off, c.xbar_en, 3'b000, c.t1_en, c.t0_en, c.eci_en};
    endfunction

    // Unpack a bus byte into stored control fields.
    function automatic ctrl_t byte_to_ctrl(logic [BUS_W-1:0] b);
        ctrl_t c;
        c.pu_off  = b[7];
        c.xbar_en = b[6];
        c.t1_en   = b[2];
        c.t0_en   = b[1];
        c.eci_en  = b[0];
        return c;
    endfunction

endpackage

// File: rtl/gpio_xbar_sync.sv
// Module: two-flop synchronizer for the pin inputs.
// Assumes pin_in is asynchronous to clk. Data is valid two edges after a change.
module gpio_xbar_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q_sync   <= '0;
        end else begin
            stage1_q <= d_async;
            q_sync   <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_xbar_regs.sv
// Module: register file holding the port latch, the control register and the mode register.
// Also holds the read mux. A read-modify-write read of the port returns the latch;
// a normal read returns the synchronized pins.
// Assumes at most one write strobe is active per cycle.
module gpio_xbar_regs
    import gpio_xbar_pkg::*;
#(
    parameter int                NPINS     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h80,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE3,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hA4,
    localparam int               SEL_W     = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_bit_wr,
    input  logic [SEL_W-1:0]  bus_bit_sel,
    input  logic              bus_bit_val,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    input  logic [NPINS-1:0]  pins_sync,
    output logic [NPINS-1:0]  bus_rdata,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  mode_q,
    output ctrl_t             ctrl_q
);
    logic hit_port, hit_ctrl, hit_mode;

    // Decode the register address.
    always_comb begin
        hit_port = (bus_addr == PORT_ADDR);
        hit_ctrl = (bus_addr == CTRL_ADDR);
        hit_mode = (bus_addr == MODE_ADDR);
    end

    // Output latch: byte writes and single-bit writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
        end else if (bus_wr && hit_port) begin
            latch_q <= bus_wdata;
        end else if (bus_bit_wr && hit_port) begin
            latch_q[bus_bit_sel] <= bus_bit_val;
        end
    end

    // Control register: only the defined fields are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr && hit_ctrl) begin
            ctrl_q <= byte_to_ctrl(bus_wdata);
        end
    end

    // Per-pin output mode: 1 = push-pull, 0 = open-drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (bus_wr && hit_mode) begin
            mode_q <= bus_wdata;
        end
    end

    // Read mux: a read-modify-write access selects the latch, otherwise the pins.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_port)      bus_rdata = bus_rmw ? latch_q : pins_sync;
            else if (hit_ctrl) bus_rdata = ctrl_to_byte(ctrl_q);
            else if (hit_mode) bus_rdata = mode_q;
        end
    end
endmodule

// File: rtl/gpio_xbar_route.sv
// Module: crossbar allocator. Enabled functions take the lowest free pins in the order
// timer 0, timer 1, counter input. Each function's input is taken from its assigned pin.
// Assumes NPINS >= 3, so that all three functions always find a pin.
module gpio_xbar_route
    import gpio_xbar_pkg::*;
#(
    parameter int  NPINS = 8,
    localparam int SEL_W = $clog2(NPINS)
) (
    input  ctrl_t            ctrl_q,
    input  logic [NPINS-1:0] pins_sync,
    output logic [NPINS-1:0] claim,
    output logic             periph_t0,
    output logic             periph_t1,
    output logic             periph_eci
);
    logic [SEL_W-1:0] t0_sel, t1_sel, eci_sel;
    logic             t0_on, t1_on, eci_on;

    // Qualify each route by the global enable.
    always_comb begin
        t0_on  = ctrl_q.xbar_en & ctrl_q.t0_en;
        t1_on  = ctrl_q.xbar_en & ctrl_q.t1_en;
        eci_on = ctrl_q.xbar_en & ctrl_q.eci_en;
    end

    // Priority allocation: each active function takes the next free pin index.
    always_comb begin
        t0_sel  = '0;
        t1_sel  = SEL_W'(t0_on);
        eci_sel = SEL_W'(t0_on) + SEL_W'(t1_on);
        claim   = '0;
        if (t0_on)  claim[t0_sel]  = 1'b1;
        if (t1_on)  claim[t1_sel]  = 1'b1;
        if (eci_on) claim[eci_sel] = 1'b1;
    end

    // Each routed input follows its pin; a function that is not routed reads 0.
    always_comb begin
        periph_t0  = t0_on  & pins_sync[t0_sel];
        periph_t1  = t1_on  & pins_sync[t1_sel];
        periph_eci = eci_on & pins_sync[eci_sel];
    end
endmodule

// File: rtl/gpio_xbar_pads.sv
// Module: per-pin drive logic. Handles push-pull and open-drain drive and weak pull-ups.
// Assumes claim is all zero while the crossbar is disabled.
module gpio_xbar_pads #(
    parameter int NPINS = 8
) (
    input  logic             xbar_en,
    input  logic             pu_off,
    input  logic [NPINS-1:0] claim,
    input  logic [NPINS-1:0] latch_q,
    input  logic [NPINS-1:0] mode_q,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pullup
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic gpio_drive;

        // The pin is GPIO-driven only when the crossbar is on and no function has claimed it.
        always_comb gpio_drive = xbar_en & ~claim[i];

        // Push-pull drives both levels; open-drain only pulls low.
        always_comb begin
            pin_oe[i]     = gpio_drive & (mode_q[i] | ~latch_q[i]);
            pin_out[i]    = gpio_drive & mode_q[i] & latch_q[i];
            pin_pullup[i] = ~pu_off & ~mode_q[i];
        end
    end
endmodule

// File: rtl/gpio_xbar_port.sv
// Module: top of the crossbar-routed GPIO port. Connects the synchronizer, the registers,
// the allocator and the pin drivers.
// Assumes a single clock domain on the bus side; the pins are asynchronous.
module gpio_xbar_port
    import gpio_xbar_pkg::*;
#(
    parameter int                NPINS     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h80,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE3,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hA4,
    localparam int               SEL_W     = $clog2(NPINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_bit_wr,
    input  logic [SEL_W-1:0]  bus_bit_sel,
    input  logic              bus_bit_val,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pullup,
    output logic              periph_t0,
    output logic              periph_t1,
    output logic              periph_eci
);
    logic [NPINS-1:0] pins_sync, latch_q, mode_q, claim;
    ctrl_t            ctrl_q;

    gpio_xbar_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pins_sync)
    );

    gpio_xbar_regs #(
        .NPINS(NPINS), .ADDR_W(ADDR_W),
        .PORT_ADDR(PORT_ADDR), .CTRL_ADDR(CTRL_ADDR), .MODE_ADDR(MODE_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_bit_wr(bus_bit_wr), .bus_bit_sel(bus_bit_sel),
        .bus_bit_val(bus_bit_val), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
        .pins_sync(pins_sync), .bus_rdata(bus_rdata), .latch_q(latch_q),
        .mode_q(mode_q), .ctrl_q(ctrl_q)
    );

    gpio_xbar_route #(.NPINS(NPINS)) u_route (
        .ctrl_q(ctrl_q), .pins_sync(pins_sync), .claim(claim),
        .periph_t0(periph_t0), .periph_t1(periph_t1), .periph_eci(periph_eci)
    );

    gpio_xbar_pads #(.NPINS(NPINS)) u_pads (
        .xbar_en(ctrl_q.xbar_en), .pu_off(ctrl_q.pu_off), .claim(claim),
        .latch_q(latch_q), .mode_q(mode_q),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pullup(pin_pullup)
    );
endmodule

// File: rtl/gpio_xbar_port_chk.sv
// Module: assertion checker bound to gpio_xbar_port. Relates the bus, the stored state
// and the pin drive across the submodules.
module gpio_xbar_port_chk #(
    parameter int                NPINS     = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h80,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hE3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic              bus_rmw,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  latch_q,
    input logic [NPINS-1:0]  mode_q,
    input logic [NPINS-1:0]  claim,
    input logic              xbar_en,
    input logic              pu_off,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_pullup
);
    // R1: a byte write to the port shows up in the latch on the next cycle.
    assert_latch_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == PORT_ADDR) |=> (latch_q == $past(bus_wdata)));

    // R1: a read-modify-write read of the port returns the latch.
    assert_rmw_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_rmw && bus_addr == PORT_ADDR) |-> (bus_rdata == latch_q));

    // R4: the unused control bits always read as zero.
    assert_ctrl_unused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CTRL_ADDR) |-> (bus_rdata[5:3] == 3'b000));

    // R5: with the crossbar disabled, no pin is driven.
    assert_xbar_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xbar_en |-> (pin_oe == '0 && pin_out == '0));

    // R6: a pin claimed by a peripheral is never driven.
    assert_claim_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & claim) == '0));

    // R8: an open-drain pin never drives high.
    assert_open_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~mode_q) == '0));

    // R9: a push-pull pin never gets a pull-up, and none is applied while pull-ups are disabled.
    assert_pullup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pullup & mode_q) == '0) && (!pu_off || pin_pullup == '0));
endmodule

bind gpio_xbar_port gpio_xbar_port_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rmw(bus_rmw), .bus_rdata(bus_rdata),
    .latch_q(latch_q), .mode_q(mode_q), .claim(claim), .xbar_en(ctrl_q.xbar_en),
    .pu_off(ctrl_q.pu_off), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pullup(pin_pullup)
);

// File: tb/gpio_xbar_port_tb.sv
// Bench for gpio_xbar_port: runs a table of configuration vectors, then directed tests.
module gpio_xbar_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    // Vector layout: {ctrl, mode, latch, exp_oe, exp_out, exp_pullup}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF},
        {8'h40, 8'hFF, 8'hA5, 8'hFF, 8'hA5, 8'h00},
        {8'h40, 8'h00, 8'hA5, 8'h5A, 8'h00, 8'hFF},
        {8'hC0, 8'h0F, 8'h3C, 8'hCF, 8'h0C, 8'h00},
        {8'h41, 8'hFF, 8'hFF, 8'hFE, 8'hFE, 8'h00},
        {8'h47, 8'hF0, 8'h00, 8'hF8, 8'h00, 8'h0F},
        {8'h46, 8'h00, 8'h0F, 8'hF0, 8'h00, 8'hFF},
        {8'h07, 8'hAA, 8'hFF, 8'h00, 8'h00, 8'h55},
        {8'h44, 8'h01, 8'h01, 8'hFE, 8'h00, 8'hFE},
        {8'h42, 8'h02, 8'h02, 8'hFE, 8'h02, 8'hFD}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = '0;
    logic       bus_wr = 1'b0, bus_bit_wr = 1'b0, bus_bit_val = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
    logic [2:0] bus_bit_sel = '0;
    logic [7:0] bus_rdata, pin_out, pin_oe, pin_pullup;
    logic       periph_t0, periph_t1, periph_eci;
    int         n_checks = 0, n_fail = 0;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_xbar_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_bit_wr(bus_bit_wr), .bus_bit_sel(bus_bit_sel),
        .bus_bit_val(bus_bit_val), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pullup(pin_pullup), .periph_t0(periph_t0), .periph_t1(periph_t1),
        .periph_eci(periph_eci)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bit_wr(logic [7:0] a, logic [2:0] s, logic v);
        @(negedge clk);
        bus_addr = a; bus_bit_sel = s; bus_bit_val = v; bus_bit_wr = 1'b1;
        @(negedge clk);
        bus_bit_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic rmw, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rmw = rmw; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0; bus_rmw = 1'b0;
    endtask

    task automatic set_pins(logic [7:0] p);
        @(negedge clk);
        pin_in = p;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: state after reset
        rd(8'h80, 1'b1, d); check("R10 latch reset", d, 8'hFF);
        rd(8'hE3, 1'b0, d); check("R10 ctrl reset", d, 8'h00);
        rd(8'hA4, 1'b0, d); check("R10 mode reset", d, 8'h00);
        check("R10 oe reset", pin_oe, 8'h00);
        check("R10 pullup reset", pin_pullup, 8'hFF);

        // Table walk over configurations: R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            wr(8'hE3, VEC[i][47:40]);
            wr(8'hA4, VEC[i][39:32]);
            wr(8'h80, VEC[i][31:24]);
            @(negedge clk);
            check("R7/R8/R5/R6 pin_oe", pin_oe, VEC[i][23:16]);
            check("R7/R8/R5 pin_out", pin_out, VEC[i][15:8]);
            check("R9 pin_pullup", pin_pullup, VEC[i][7:0]);
            rd(8'hE3, 1'b0, d); check("R4 ctrl readback", d, VEC[i][47:40] & 8'hC7);
            rd(8'h80, 1'b1, d); check("R1 rmw latch read", d, VEC[i][31:24]);
        end

        // R4: unused bits ignored, unmapped address reads 0
        wr(8'hE3, 8'hFF);
        rd(8'hE3, 1'b0, d); check("R4 unused bits", d, 8'hC7);
        rd(8'h55, 1'b0, d); check("R4 unmapped read", d, 8'h00);

        // R2: a normal read returns the pins, including claimed pins, two edges late
        wr(8'hE3, 8'h47);
        wr(8'h80, 8'h00);
        @(negedge clk);
        pin_in = 8'h5A;
        @(negedge clk);
        rd(8'h80, 1'b0, d); check("R2 pin read latency", d, 8'h5A);
        rd(8'h80, 1'b1, d); check("R1 rmw ignores pins", d, 8'h00);
        pin_in = 8'hA5;
        @(negedge clk);
        #1 d = 8'h00;
        bus_addr = 8'h80; bus_rd = 1'b1; #1 d = bus_rdata; bus_rd = 1'b0;
        check("R2 one edge not yet", d, 8'h5A);
        @(negedge clk);
        rd(8'h80, 1'b0, d); check("R2 second value", d, 8'hA5);

        // R6: ctrl 0x47 puts t0 on pin0, t1 on pin1, counter on pin2
        set_pins(8'h05);
        check("R6 t0 pin0", {7'd0, periph_t0}, 8'd1);
        check("R6 t1 pin1", {7'd0, periph_t1}, 8'd0);
        check("R6 eci pin2", {7'd0, periph_eci}, 8'd1);
        // ctrl 0x43 puts t0 on pin0 and the counter on pin1
        wr(8'hE3, 8'h43);
        set_pins(8'h02);
        check("R6 t0 pin0 low", {7'd0, periph_t0}, 8'd0);
        check("R6 eci moves to pin1", {7'd0, periph_eci}, 8'd1);
        check("R6 t1 unrouted", {7'd0, periph_t1}, 8'd0);
        // R5: crossbar off, inputs read 0
        wr(8'hE3, 8'h07);
        set_pins(8'hFF);
        check("R5 periph off", {5'd0, periph_t0, periph_t1, periph_eci}, 8'd0);

        // R3: single-bit write changes one bit only
        wr(8'h80, 8'h00);
        bit_wr(8'h80, 3'd5, 1'b1);
        rd(8'h80, 1'b1, d); check("R3 set bit5", d, 8'h20);
        wr(8'h80, 8'hFF);
        bit_wr(8'h80, 3'd0, 1'b0);
        rd(8'h80, 1'b1, d); check("R3 clear bit0", d, 8'hFE);
        bit_wr(8'hE3, 3'd1, 1'b1);
        rd(8'h80, 1'b1, d); check("R3 other address no effect", d, 8'hFE);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule